// File: doc/BRIEF.md
# Timer Clock Select and Stop-Mode Gating

This block controls two down-counting timers that share one control register: a periodic interrupt timer and a watchdog timer. For each timer, one control bit picks the count source. The source is either an always-present internal reference tick or an external oscillator tick. A second bit lets that timer keep counting while the chip sits in the low-power pseudo-stop mode.

The select bits are interlocked with the oscillator-ready status. The oscillator can be chosen only while it is ready, and losing readiness drops both timers back to the internal reference. Any change of a select bit, whether written by software or forced by the interlock, restarts that timer from its full timeout.

In stop mode a timer that is not allowed to run freezes and keeps its count. It carries on from that count once stop mode ends.

Both source clocks arrive as single-cycle tick strobes on one fast system clock. Each timer advances only in cycles where its count-enable is high. The periodic timer raises a one-cycle interrupt each time it wraps. The watchdog raises a one-cycle timeout when it wraps, unless a service strobe has reloaded it first.

Top module: `tmr_clk_gate`

## Requirements
- R1: A timer's clock-enable output equals `osc_tick` while its select bit is 1 and `irc_tick` while it is 0, in the same cycle. The control word `wr_data` uses bit 0 for the periodic select, bit 1 for the watchdog select, bit 2 for the periodic pseudo-stop enable and bit 3 for the watchdog pseudo-stop enable.
- R2: A write taken while `osc_ready` is 0 leaves both select bits at 0. The pseudo-stop enable bits are still written.
- R3: While `osc_ready` is 0, both select bits are 0 from the next clock edge on.
- R4: If a select bit differs after a clock edge from its value before that edge, the timer's restart output is high for exactly the following cycle, and the counter holds its full load value one edge later. This applies whether the change came from a write or from the R3 interlock.
- R5: Outside stop mode (`stop_mode`=0), a timer's count-enable equals its clock-enable.
- R6: In stop mode, a timer's count-enable equals its clock-enable only when `pstop_mode`, its pseudo-stop enable and its select bit are all 1. Otherwise its count-enable is 0.
- R7: In a cycle with no count-enable and no reload, a counter keeps its value. It resumes counting from that value when enabled again.
- R8: A counter decrements by one on each count-enable. On a count-enable at 0 it reloads its full value, and its flag (`per_irq` or `wdg_timeout`) is high for the one cycle after that edge.
- R9: `wdg_service` reloads the watchdog to its full value at the next edge and suppresses the timeout for that edge. It has no effect on the periodic timer.
- R10: After reset, all four control bits are 0, both counters hold their load values, and restart and flag outputs are 0.
- R11: The two timers follow these rules independently. A write or mode change affects each timer only through its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Control word: [0] periodic select, [1] watchdog select, [2] periodic pseudo-stop enable, [3] watchdog pseudo-stop enable |
| osc_ready | input | 1 | External oscillator ready status |
| stop_mode | input | 1 | Chip is in stop mode |
| pstop_mode | input | 1 | Stop mode is the pseudo-stop variant |
| irc_tick | input | 1 | Internal reference clock tick strobe |
| osc_tick | input | 1 | External oscillator clock tick strobe |
| wdg_service | input | 1 | Watchdog service (reload) strobe |
| per_clk_en | output | 1 | Periodic timer selected-clock enable |
| per_cnt_en | output | 1 | Periodic timer count-enable |
| per_restart | output | 1 | Periodic timer restart pulse |
| per_irq | output | 1 | Periodic timer wrap interrupt pulse |
| per_count | output | CNT_W | Periodic timer count |
| wdg_clk_en | output | 1 | Watchdog selected-clock enable |
| wdg_cnt_en | output | 1 | Watchdog count-enable |
| wdg_restart | output | 1 | Watchdog restart pulse |
| wdg_timeout | output | 1 | Watchdog timeout pulse |
| wdg_count | output | CNT_W | Watchdog count |

## Verification
Directed phases come first. A select write while the oscillator is not ready tells a working interlock apart from a bit that latched anyway. A write while it is ready shows the restart pulse and the source switch. Full stop against pseudo-stop, with only one timer's pseudo-stop enable set, separates the three-way enable condition and shows that the two timers are independent. Dropping oscillator-ready while an oscillator source is selected confirms that a forced change restarts the timer. Random traffic follows. It mixes sparse writes, service strobes, mode toggles and independent tick strobes, so that wrap, freeze and resume and restart collisions all occur against a cycle model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_TMR = 2;
  localparam int unsigned TMR_PER = 0;
  localparam int unsigned TMR_WDG = 1;
  localparam int unsigned CTRL_W  = 2 * NUM_TMR;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg #(
  parameter int unsigned N = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*N-1:0] wr_data,
  input  logic           osc_ready,
  output logic [N-1:0]   sel_q,
  output logic [N-1:0]   pse_q,
  output logic [N-1:0]   restart_q
);
  logic [N-1:0] sel_d, pse_d, restart_d;

  always_comb begin
    pse_d = pse_q;
    if (wr_en) pse_d = wr_data[2*N-1:N];
    if (!osc_ready)  sel_d = '0;
    else if (wr_en)  sel_d = wr_data[N-1:0];
    else             sel_d = sel_q;
    restart_d = sel_d ^ sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      pse_q     <= '0;
      restart_q <= '0;
    end else begin
      sel_q     <= sel_d;
      pse_q     <= pse_d;
      restart_q <= restart_d;
    end
  end
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate (
  input  logic sel,
  input  logic pse,
  input  logic irc_tick,
  input  logic osc_tick,
  input  logic stop_mode,
  input  logic pstop_mode,
  output logic clk_en,
  output logic cnt_en
);
  logic run_ok;

  always_comb begin
    clk_en = sel ? osc_tick : irc_tick;
    run_ok = !stop_mode || (pstop_mode && pse && sel);
    cnt_en = clk_en && run_ok;
  end
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int unsigned W    = 8,
  parameter int unsigned LOAD = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic         cnt_en,
  output logic [W-1:0] count,
  output logic         flag
);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);
  logic [W-1:0] cnt_d;
  logic         flag_d;

  always_comb begin
    cnt_d  = count;
    flag_d = 1'b0;
    if (reload) begin
      cnt_d = LOAD_V;
    end else if (cnt_en) begin
      if (count == '0) begin
        cnt_d  = LOAD_V;
        flag_d = 1'b1;
      end else begin
        cnt_d = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= LOAD_V;
      flag  <= 1'b0;
    end else begin
      count <= cnt_d;
      flag  <= flag_d;
    end
  end
endmodule

// File: rtl/tmr_clk_gate.sv
module tmr_clk_gate
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PER_LOAD = 5,
  parameter int unsigned WDG_LOAD = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              osc_ready,
  input  logic              stop_mode,
  input  logic              pstop_mode,
  input  logic              irc_tick,
  input  logic              osc_tick,
  input  logic              wdg_service,
  output logic              per_clk_en,
  output logic              per_cnt_en,
  output logic              per_restart,
  output logic              per_irq,
  output logic [CNT_W-1:0]  per_count,
  output logic              wdg_clk_en,
  output logic              wdg_cnt_en,
  output logic              wdg_restart,
  output logic              wdg_timeout,
  output logic [CNT_W-1:0]  wdg_count
);
  logic [NUM_TMR-1:0] sel_q, pse_q, restart_q;
  logic [NUM_TMR-1:0] clk_en, cnt_en, reload, flag;
  logic [CNT_W-1:0]   count [NUM_TMR];
  logic [NUM_TMR-1:0] service;

  assign service = {wdg_service, 1'b0};

  tmr_ctrl_reg #(.N(NUM_TMR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .osc_ready (osc_ready),
    .sel_q     (sel_q),
    .pse_q     (pse_q),
    .restart_q (restart_q)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int unsigned LD = (i == TMR_PER) ? PER_LOAD : WDG_LOAD;

    tmr_gate u_gate (
      .sel        (sel_q[i]),
      .pse        (pse_q[i]),
      .irc_tick   (irc_tick),
      .osc_tick   (osc_tick),
      .stop_mode  (stop_mode),
      .pstop_mode (pstop_mode),
      .clk_en     (clk_en[i]),
      .cnt_en     (cnt_en[i])
    );

    assign reload[i] = restart_q[i] | service[i];

    tmr_down_cnt #(.W(CNT_W), .LOAD(LD)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (reload[i]),
      .cnt_en (cnt_en[i]),
      .count  (count[i]),
      .flag   (flag[i])
    );
  end

  assign per_clk_en  = clk_en[TMR_PER];
  assign per_cnt_en  = cnt_en[TMR_PER];
  assign per_restart = restart_q[TMR_PER];
  assign per_irq     = flag[TMR_PER];
  assign per_count   = count[TMR_PER];
  assign wdg_clk_en  = clk_en[TMR_WDG];
  assign wdg_cnt_en  = cnt_en[TMR_WDG];
  assign wdg_restart = restart_q[TMR_WDG];
  assign wdg_timeout = flag[TMR_WDG];
  assign wdg_count   = count[TMR_WDG];
endmodule

// File: rtl/tmr_clk_gate_chk.sv
module tmr_clk_gate_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PER_LOAD = 5,
  parameter int unsigned WDG_LOAD = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_ready,
  input logic             stop_mode,
  input logic             pstop_mode,
  input logic             wdg_service,
  input logic [1:0]       sel_q,
  input logic             per_cnt_en,
  input logic             per_restart,
  input logic             per_irq,
  input logic [CNT_W-1:0] per_count,
  input logic             wdg_cnt_en,
  input logic             wdg_restart,
  input logic             wdg_timeout,
  input logic [CNT_W-1:0] wdg_count
);
  // R3
  osc_loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_ready |=> (sel_q == 2'b00));

  // R4
  per_restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_restart |=> (per_count == CNT_W'(PER_LOAD)));

  // R4
  wdg_restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_restart |=> (wdg_count == CNT_W'(WDG_LOAD)));

  // R6
  full_stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !pstop_mode) |-> (!per_cnt_en && !wdg_cnt_en));

  // R7
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_cnt_en && !per_restart) |=> $stable(per_count));

  // R8
  per_irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |-> (per_count == CNT_W'(PER_LOAD)));

  // R9
  wdg_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_service |=> (!wdg_timeout && wdg_count == CNT_W'(WDG_LOAD)));
endmodule

bind tmr_clk_gate tmr_clk_gate_chk #(
  .CNT_W(CNT_W), .PER_LOAD(PER_LOAD), .WDG_LOAD(WDG_LOAD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .osc_ready   (osc_ready),
  .stop_mode   (stop_mode),
  .pstop_mode  (pstop_mode),
  .wdg_service (wdg_service),
  .sel_q       (sel_q),
  .per_cnt_en  (per_cnt_en),
  .per_restart (per_restart),
  .per_irq     (per_irq),
  .per_count   (per_count),
  .wdg_cnt_en  (wdg_cnt_en),
  .wdg_restart (wdg_restart),
  .wdg_timeout (wdg_timeout),
  .wdg_count   (wdg_count)
);

// File: tb/sim_tmr_clk_gate.sv
`timescale 1ns/1ps
module sim_tmr_clk_gate;
  localparam int CNT_W = 8;
  localparam int PER_LOAD = 5;
  localparam int WDG_LOAD = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, osc_ready = 0, stop_mode = 0, pstop_mode = 0;
  logic irc_tick = 0, osc_tick = 0, wdg_service = 0;
  logic [3:0] wr_data = '0;
  logic per_clk_en, per_cnt_en, per_restart, per_irq;
  logic wdg_clk_en, wdg_cnt_en, wdg_restart, wdg_timeout;
  logic [CNT_W-1:0] per_count, wdg_count;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  logic [1:0] m_sel, m_pse, m_rs, m_flag;
  int m_cnt [2];

  always #2.5 clk = ~clk;

  tmr_clk_gate #(.CNT_W(CNT_W), .PER_LOAD(PER_LOAD), .WDG_LOAD(WDG_LOAD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .osc_ready(osc_ready), .stop_mode(stop_mode), .pstop_mode(pstop_mode),
    .irc_tick(irc_tick), .osc_tick(osc_tick), .wdg_service(wdg_service),
    .per_clk_en(per_clk_en), .per_cnt_en(per_cnt_en), .per_restart(per_restart),
    .per_irq(per_irq), .per_count(per_count),
    .wdg_clk_en(wdg_clk_en), .wdg_cnt_en(wdg_cnt_en), .wdg_restart(wdg_restart),
    .wdg_timeout(wdg_timeout), .wdg_count(wdg_count)
  );

  function automatic int load_of(int i);
    return (i == 0) ? PER_LOAD : WDG_LOAD;
  endfunction

  function automatic logic exp_clk_en(int i);
    return m_sel[i] ? osc_tick : irc_tick;
  endfunction

  function automatic logic exp_cnt_en(int i);
    return exp_clk_en(i) && (!stop_mode || (pstop_mode && m_pse[i] && m_sel[i]));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sel = '0; m_pse = '0; m_rs = '0; m_flag = '0;
    for (int i = 0; i < 2; i++) m_cnt[i] = load_of(i);
  endtask

  task automatic model_step();
    logic [1:0] sel_n, pse_n, cen;
    for (int i = 0; i < 2; i++) cen[i] = exp_cnt_en(i);
    pse_n = wr_en ? wr_data[3:2] : m_pse;
    sel_n = !osc_ready ? 2'b00 : (wr_en ? wr_data[1:0] : m_sel);
    for (int i = 0; i < 2; i++) begin
      logic rl;
      rl = m_rs[i] || (i == 1 && wdg_service);
      m_flag[i] = 1'b0;
      if (rl) m_cnt[i] = load_of(i);
      else if (cen[i]) begin
        if (m_cnt[i] == 0) begin m_cnt[i] = load_of(i); m_flag[i] = 1'b1; end
        else m_cnt[i] = m_cnt[i] - 1;
      end
    end
    m_rs = sel_n ^ m_sel;
    m_sel = sel_n;
    m_pse = pse_n;
  endtask

  task automatic compare_all();
    // R1 R2 R3 R11: source selection per timer
    check("R1 R2 R3 R11 per_clk_en", per_clk_en, exp_clk_en(0));
    check("R1 R2 R3 R11 wdg_clk_en", wdg_clk_en, exp_clk_en(1));
    // R5 R6
    check("R5 R6 per_cnt_en", per_cnt_en, exp_cnt_en(0));
    check("R5 R6 wdg_cnt_en", wdg_cnt_en, exp_cnt_en(1));
    // R4
    check("R4 per_restart", per_restart, m_rs[0]);
    check("R4 wdg_restart", wdg_restart, m_rs[1]);
    // R7 R8 R9
    check("R7 R8 per_count", per_count, m_cnt[0]);
    check("R7 R8 R9 wdg_count", wdg_count, m_cnt[1]);
    check("R8 per_irq", per_irq, m_flag[0]);
    check("R8 R9 wdg_timeout", wdg_timeout, m_flag[1]);
  endtask

  // one cycle: drive after falling edge, compare, model the rising edge
  task automatic cycle(logic we, logic [3:0] wd, logic ordy, logic stp, logic pstp,
                       logic it, logic ot, logic svc);
    @(negedge clk);
    wr_en = we; wr_data = wd; osc_ready = ordy; stop_mode = stp;
    pstop_mode = pstp; irc_tick = it; osc_tick = ot; wdg_service = svc;
    #1;
    compare_all();
    @(posedge clk);
    model_step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    check("R10 per_count", per_count, PER_LOAD);
    check("R10 wdg_count", wdg_count, WDG_LOAD);
    check("R10 restart", {per_restart, wdg_restart}, 0);
    check("R10 flags", {per_irq, wdg_timeout}, 0);

    // R10: both selects at 0, so internal ticks pass and oscillator ticks do not
    cycle(0, 4'h0, 1, 0, 0, 1, 0, 0);
    cycle(0, 4'h0, 1, 0, 0, 0, 1, 0);
    // R2: select write without oscillator ready is refused, pse bits still land
    cycle(1, 4'hF, 0, 0, 0, 0, 1, 0);
    cycle(0, 4'h0, 0, 0, 0, 0, 1, 0);
    cycle(0, 4'h0, 1, 0, 0, 0, 1, 0);
    // R4: accepted select writes restart both timers
    cycle(1, 4'b0111, 1, 0, 0, 0, 1, 0);
    cycle(0, 4'h0, 1, 0, 0, 0, 1, 0);
    cycle(0, 4'h0, 1, 0, 0, 0, 1, 0);
    // R6 R11: pseudo-stop, only the periodic timer may run
    repeat (4) cycle(0, 4'h0, 1, 1, 1, 0, 1, 0);
    // R6 R7: full stop freezes both, then resume
    repeat (4) cycle(0, 4'h0, 1, 1, 0, 1, 1, 0);
    repeat (3) cycle(0, 4'h0, 1, 0, 0, 0, 1, 0);
    // R3 R4: losing oscillator ready forces selects back and restarts
    cycle(0, 4'h0, 0, 0, 0, 1, 0, 0);
    repeat (3) cycle(0, 4'h0, 1, 0, 0, 1, 0, 0);
    // R8 R9: run to wrap, then service
    repeat (12) cycle(0, 4'h0, 1, 0, 0, 1, 0, 0);
    cycle(0, 4'h0, 1, 0, 0, 1, 0, 1);
    cycle(0, 4'h0, 1, 0, 0, 1, 0, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic we, ordy, stp, pstp, it, ot, svc;
      we   = ($urandom_range(0, 9) == 0);
      ordy = ($urandom_range(0, 11) != 0);
      stp  = ($urandom_range(0, 3) == 0);
      pstp = $urandom_range(0, 1);
      it   = ($urandom_range(0, 2) != 0);
      ot   = ($urandom_range(0, 2) != 0);
      svc  = ($urandom_range(0, 24) == 0);
      cycle(we, 4'($urandom_range(0, 15)), ordy, stp, pstp, it, ot, svc);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule